// File: doc/BRIEF.md
# Audio Clock Divider with Odd Ratio

This block produces the clocks that an audio serial-bus master needs from a single fast kernel clock. A programmable ratio N is formed from an 8-bit divide field and a separate odd bit as N = 2×div + odd. Because of the odd bit, N can be odd, and the divided waveform then has high and low phases that differ by one kernel cycle. Divide values of 0 and 1 are not legal and are treated as a ratio of 2.

When the master-clock output is turned on, the divided clock appears on `mck_o` at 256×fs. The bit clock is then made from it by a further fixed division: 8 for 16-bit channels or 4 for 32-bit channels, so fs is the kernel clock over 256×N in both cases. For example, a 48 MHz kernel clock with div 8 and odd 1 gives about 11029.41 Hz. When the master clock is turned off, `mck_o` stays low and the bit clock is the divided clock itself.

Along with the bit-clock level, the block gives a one-cycle tick that marks each rising bit-clock edge. A serializer uses this tick as a clock enable. Dropping `en`, or changing any configuration input, sends every counter back to zero so that a new setting starts from a clean phase.

Top module: `audio_clk_div`

## Requirements
- R1: The ratio is N = 2×div_i + odd_i; when div_i is 0 or 1 the ratio is 2 and odd_i has no effect.
- R2: With mck_en_i=1, mck_o is periodic with period N kernel cycles, high for div_i+odd_i cycles and low for div_i cycles (1 and 1 when div_i<2).
- R3: With mck_en_i=0, mck_o stays low.
- R4: With mck_en_i=0, bclk_o has period N, high for div_i+odd_i cycles and low for div_i cycles (1 and 1 when div_i<2).
- R5: With mck_en_i=1, bclk_o has period 8×N when chan32_i=0 (16-bit channels) and 4×N when chan32_i=1 (32-bit channels), with equal high and low phases, so that each bit-clock period holds 8 or 4 master-clock periods and fs = kernel/(256×N).
- R6: bclk_tick_o is a single-cycle pulse that is high in exactly those cycles where bclk_o goes from low to high.
- R7: While en is low, all three outputs are low. The first tick appears in the first cycle after the first rising clock edge that sees en high.
- R8: A change of any configuration input (div_i, odd_i, mck_en_i, chan32_i) drives all outputs low in the next cycle, and a tick follows in the cycle after that.
- R9: After synchronous reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the counters at zero |
| div_i | input | DIV_W (8) | Linear divide field |
| odd_i | input | 1 | Adds one kernel cycle to the ratio |
| mck_en_i | input | 1 | Drive the master clock and derive the bit clock from it |
| chan32_i | input | 1 | Channel length: 0 = 16-bit, 1 = 32-bit |
| mck_o | output | 1 | Master clock output (registered) |
| bclk_o | output | 1 | Bit-clock level (registered) |
| bclk_tick_o | output | 1 | One-cycle pulse on each bit-clock rising edge |

## Verification
The hard case is the phase relationship between the two counter stages. With the master clock on, the prescaler may only advance on a wrap of the ratio counter, and an odd ratio makes the master-clock duty unequal while the bit clock must remain exactly symmetric. To reach every pairing, the bench sweeps every combination of div 0 to 12, both odd values, both master-clock settings and both channel lengths, and also the largest divide value. Each step changes the configuration, so every step also tests the restart sequence. In each step the bench measures a full bit-clock period and counts the high cycles of both clocks and the master-clock rising edges within it.

// File: rtl/acd_pkg.sv
package acd_pkg;
  // Master-clock periods per bit-clock period for each channel length
  localparam int MCK_PER_BIT_CH16 = 8;
  localparam int MCK_PER_BIT_CH32 = 4;
  localparam int MCK_PER_BIT_MAX  = MCK_PER_BIT_CH16;

  typedef enum logic {
    CH_16 = 1'b0,
    CH_32 = 1'b1
  } chan_len_e;
endpackage

// File: rtl/acd_ratio_cnt.sv
// Kernel-cycle counter for the 2*div+odd ratio, with the phase decode.
module acd_ratio_cnt #(
  parameter int DIV_W = 8,
  localparam int CW = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  input  logic             odd,
  output logic             at_start,
  output logic             wrap,
  output logic             hi_phase
);
  logic [CW-1:0] n_tot;
  logic [CW-1:0] hi_len;
  logic [CW-1:0] cnt;

  // Illegal small divide values fall back to a ratio of two
  always_comb begin
    if (div < DIV_W'(2)) begin
      n_tot  = CW'(2);
      hi_len = CW'(1);
    end else begin
      n_tot  = {div, 1'b0} + CW'(odd);
      hi_len = {1'b0, div} + CW'(odd);
    end
  end

  assign at_start = (cnt == '0);
  assign wrap     = (cnt == n_tot - CW'(1));
  assign hi_phase = (cnt < hi_len);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/acd_bit_presc.sv
// Counts master-clock periods to form the bit clock when the master clock is on.
module acd_bit_presc
  import acd_pkg::*;
#(
  parameter int R16 = MCK_PER_BIT_CH16,
  parameter int R32 = MCK_PER_BIT_CH32,
  localparam int RMAX = (R16 > R32) ? R16 : R32,
  localparam int PW = $clog2(RMAX)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      restart,
  input  logic      step,
  input  chan_len_e chan,
  output logic      at_start,
  output logic      level
);
  logic [PW-1:0] pcnt;
  logic [PW-1:0] last_idx;
  logic [PW-1:0] half;

  always_comb begin
    if (chan == CH_32) begin
      last_idx = PW'(R32 - 1);
      half     = PW'(R32 / 2);
    end else begin
      last_idx = PW'(R16 - 1);
      half     = PW'(R16 / 2);
    end
  end

  assign at_start = (pcnt == '0);
  assign level    = (pcnt < half);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt <= '0;
    end else if (step) begin
      pcnt <= (pcnt == last_idx) ? '0 : pcnt + PW'(1);
    end
  end
endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div
  import acd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mck_en_i,
  input  logic             chan32_i,
  output logic             mck_o,
  output logic             bclk_o,
  output logic             bclk_tick_o
);
  localparam int CFG_W = DIV_W + 3;

  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             restart;
  logic             r_start, r_wrap, r_hi;
  logic             p_start, p_level;
  chan_len_e        chan;

  assign cfg_now = {div_i, odd_i, mck_en_i, chan32_i};
  assign chan    = chan_len_e'(chan32_i);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_now;
  end

  // Any configuration edit or disable returns both stages to phase zero
  assign restart = !en || (cfg_now != cfg_q);

  acd_ratio_cnt #(.DIV_W(DIV_W)) u_ratio (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .div      (div_i),
    .odd      (odd_i),
    .at_start (r_start),
    .wrap     (r_wrap),
    .hi_phase (r_hi)
  );

  acd_bit_presc u_presc (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .step     (r_wrap && mck_en_i),
    .chan     (chan),
    .at_start (p_start),
    .level    (p_level)
  );

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      mck_o       <= 1'b0;
      bclk_o      <= 1'b0;
      bclk_tick_o <= 1'b0;
    end else begin
      mck_o <= mck_en_i && r_hi;
      if (mck_en_i) begin
        bclk_o      <= p_level;
        bclk_tick_o <= r_start && p_start;
      end else begin
        bclk_o      <= r_hi;
        bclk_tick_o <= r_start;
      end
    end
  end
endmodule

// File: rtl/audio_clk_div_chk.sv
module audio_clk_div_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic mck_en_i,
  input logic mck_o,
  input logic bclk_o,
  input logic bclk_tick_o
);
  // R6: a tick only where the bit clock rises
  p_tick_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    bclk_tick_o |-> $rose(bclk_o));

  // R6: every bit-clock rise carries a tick
  p_rise_has_tick_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk_o) |-> bclk_tick_o);

  // R6: the tick never lasts two cycles
  p_tick_single_r6: assert property (@(posedge clk) disable iff (rst)
    bclk_tick_o |=> !bclk_tick_o);

  // R3: master clock silent when not enabled
  p_mck_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !mck_en_i |=> !mck_o);

  // R7: everything idle while disabled
  p_idle_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!mck_o && !bclk_o && !bclk_tick_o));
endmodule

bind audio_clk_div audio_clk_div_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .mck_en_i    (mck_en_i),
  .mck_o       (mck_o),
  .bclk_o      (bclk_o),
  .bclk_tick_o (bclk_tick_o)
);

// File: tb/tb_audio_clk_div.sv
module tb_audio_clk_div;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en = 1'b0;
  logic [DIV_W-1:0] div_i = '0;
  logic             odd_i = 1'b0;
  logic             mck_en_i = 1'b0;
  logic             chan32_i = 1'b0;
  logic             mck_o, bclk_o, bclk_tick_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  audio_clk_div #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst(rst), .en(en), .div_i(div_i), .odd_i(odd_i),
    .mck_en_i(mck_en_i), .chan32_i(chan32_i),
    .mck_o(mck_o), .bclk_o(bclk_o), .bclk_tick_o(bclk_tick_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Apply a configuration (must differ from the current one) and measure one bit-clock period
  task automatic run_cfg(input int d, input bit o, input bit m, input bit c);
    int n, hi, mr, len_e, hb_e, hm_e, rise_e;
    int len, hb, hm, rises;
    bit prev_m, done;
    n  = (d < 2) ? 2 : 2 * d + o;                 // R1
    hi = (d < 2) ? 1 : d + o;
    mr = c ? 4 : 8;
    len_e  = m ? mr * n : n;
    hb_e   = m ? (mr / 2) * n : hi;
    hm_e   = m ? mr * hi : 0;
    rise_e = m ? mr : 0;

    @(negedge clk);
    div_i = DIV_W'(d); odd_i = o; mck_en_i = m; chan32_i = c;
    @(negedge clk);
    chk($sformatf("R8 outputs low after change d=%0d o=%0d m=%0d c=%0d", d, o, m, c),
        int'({mck_o, bclk_o, bclk_tick_o}), 0);
    @(negedge clk);
    chk($sformatf("R8 tick after restart d=%0d o=%0d m=%0d c=%0d", d, o, m, c),
        int'(bclk_tick_o), 1);

    len = 0; hb = 0; hm = 0; rises = 0; prev_m = 1'b0; done = 1'b0;
    while (!done) begin
      len++;
      hb += int'(bclk_o);
      hm += int'(mck_o);
      if (mck_o && !prev_m) rises++;
      prev_m = mck_o;
      @(negedge clk);
      if (bclk_tick_o || len > len_e + 8) done = 1'b1;
    end
    chk($sformatf("%s bclk period d=%0d o=%0d m=%0d c=%0d", m ? "R5" : "R1/R4", d, o, m, c),
        len, len_e);
    chk($sformatf("%s bclk high d=%0d o=%0d m=%0d c=%0d", m ? "R5" : "R4", d, o, m, c),
        hb, hb_e);
    chk($sformatf("%s mck high cycles d=%0d o=%0d m=%0d c=%0d", m ? "R2" : "R3", d, o, m, c),
        hm, hm_e);
    chk($sformatf("%s mck rises per bclk d=%0d o=%0d m=%0d c=%0d", m ? "R2" : "R3", d, o, m, c),
        rises, rise_e);
    if (m) chk($sformatf("R5 fs ratio d=%0d o=%0d c=%0d", d, o, c),
               len * (c ? 64 : 32), 256 * n);
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 outputs after reset", int'({mck_o, bclk_o, bclk_tick_o}), 0);
    rst = 1'b0;
    div_i = 8'd3; mck_en_i = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      odd_i = k[0];
      chk("R7 outputs idle while disabled", int'({mck_o, bclk_o, bclk_tick_o}), 0);
    end
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk("R7 first tick after enable", int'(bclk_tick_o), 1);
    chk("R2 mck high at first phase", int'(mck_o), 1);

    for (int d = 0; d <= 12; d++)
      for (int o = 0; o < 2; o++)
        for (int m = 0; m < 2; m++)
          for (int c = 0; c < 2; c++)
            run_cfg(d, o[0], m[0], c[0]);
    run_cfg(255, 1'b1, 1'b0, 1'b1);
    run_cfg(255, 1'b1, 1'b1, 1'b0);

    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R7 outputs drop when disabled", int'({mck_o, bclk_o, bclk_tick_o}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule